// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Adjacent-Row Refresh

This block decides when a DRAM array is refreshed. It sits between a CPU-side row request port and a plain command output that carries activate and refresh commands. A free-running interval timer, loaded from a configuration input, raises a refresh request. Before any refresh command is sent, the scheduler asks for the memory bus with a hold request and waits for the hold acknowledge. While the bus is held the CPU sees its ready line low. Once the bus is granted, the scheduler refreshes every row of the array in ascending order. It keeps no record of which rows were used recently.

Each row the CPU activates can disturb the cells in the two rows next to it. For that reason every accepted activation of row R queues a refresh of R-1 and R+1 in a small queue. The queued refreshes also run under a bus hold, and they finish before the next CPU request is taken. Each refresh command occupies a fixed number of cycles. When the last refresh of a session is complete, the bus is released and the CPU may issue again in the same cycle.

Top module: `dref_sched`

## Requirements
- R1: With `cfg_interval` = N > 0 the timer raises a refresh request every N cycles, so consecutive refresh sessions start (rising `hold_req`) exactly N cycles apart when each session is shorter than N. With `cfg_interval` = 0 no refresh request is raised.
- R2: A refresh command (`cmd_kind` = 2) is issued only while `hold_req` is high and `hold_ack` has been returned. A late acknowledge delays the first refresh.
- R3: While `hold_req` is high, `cpu_ready` is low and a pending `cpu_req` is not accepted. The request is accepted after the bus is released.
- R4: A timer-triggered session refreshes rows 0 to ROWS-1 in ascending order. On `cmd_kind`, 0 means no command, 1 an activate and 2 a refresh, and `cmd_row` is always below ROWS.
- R5: A CPU request is accepted when both `cpu_req` and `cpu_ready` are high at a clock edge. In the next cycle the block emits one activate of that row. This is followed by a refresh of row R-1 and then one of row R+1, lower row first.
- R6: Activating row 0 queues only a refresh of row 1. Activating row ROWS-1 queues only a refresh of row ROWS-2. Row addresses never wrap.
- R7: Within one session, consecutive refresh commands are exactly CMD_CYCLES cycles apart.
- R8: `hold_req` falls exactly CMD_CYCLES cycles after the last refresh of a session. If nothing is pending, `cpu_ready` is high in that same cycle.
- R9: Timer expiries that fall inside a sweep are latched as a single pending request. They produce exactly one further sweep, never more.
- R10: While any adjacent-row refresh is queued, `cpu_ready` stays low. This includes the cycle in which the activate appears.
- R11: After reset, `hold_req` and `cmd_valid` are low and `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | TIMER_W | Refresh interval in cycles, 0 disables the timer |
| cpu_req | input | 1 | CPU asks to activate a row |
| cpu_row | input | ROW_W | Row the CPU wants to activate |
| cpu_ready | output | 1 | CPU request will be accepted at the next edge |
| hold_req | output | 1 | Bus hold request to the arbiter |
| hold_ack | input | 1 | Bus hold granted |
| cmd_valid | output | 1 | A DRAM command is present this cycle |
| cmd_kind | output | 2 | 0 none, 1 activate, 2 refresh |
| cmd_row | output | ROW_W | Row addressed by the command |

## Verification
Activations are tried on an interior row, on row 0 and on the last row. Comparing them separates correct neighbour generation from wrapping or missing edge handling. A second request held high while a neighbour session runs, under a slow acknowledge, shows whether hold blocks acceptance and whether refreshes wait for the grant. A steady interval checks session spacing and full ascending sweeps. An interval shorter than a sweep, switched off after the first sweep ends, tells a single latched request apart from stacked or lost ones.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_REF = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } sched_st_e;

endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
    parameter int TIMER_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] cfg_interval,
    output logic               tick
);

    typedef struct packed {
        logic [TIMER_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;
    logic expire;

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        if (cfg_interval == '0) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt >= cfg_interval - 1'b1) begin
            expire    = 1'b1;
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick = expire;

endmodule

// File: rtl/dref_nbr_fifo.sv
module dref_nbr_fifo #(
    parameter int ROW_W = 13,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_lo,
    input  logic [ROW_W-1:0] lo_row,
    input  logic             push_hi,
    input  logic [ROW_W-1:0] hi_row,
    input  logic             pop,
    output logic             empty,
    output logic [ROW_W-1:0] head_row
);

    localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][ROW_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t fq_q, fq_d;
    logic [PTR_W-1:0] wp;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fq_d = fq_q;
        wp   = fq_q.wr;
        if (pop && fq_q.cnt != '0) begin
            fq_d.rd  = step(fq_q.rd);
            fq_d.cnt = fq_d.cnt - 1'b1;
        end
        if (push_lo && fq_d.cnt < FULL_CNT) begin
            fq_d.mem[wp] = lo_row;
            wp           = step(wp);
            fq_d.cnt     = fq_d.cnt + 1'b1;
        end
        if (push_hi && fq_d.cnt < FULL_CNT) begin
            fq_d.mem[wp] = hi_row;
            wp           = step(wp);
            fq_d.cnt     = fq_d.cnt + 1'b1;
        end
        fq_d.wr = wp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fq_q <= '0;
        else        fq_q <= fq_d;
    end

    assign empty    = (fq_q.cnt == '0);
    assign head_row = fq_q.mem[fq_q.rd];

endmodule

// File: rtl/dref_sched.sv
module dref_sched
    import dref_pkg::*;
#(
    parameter int ROWS       = 8192,
    parameter int TIMER_W    = 22,
    parameter int CMD_CYCLES = 4,
    parameter int FIFO_DEPTH = 4,
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] cfg_interval,
    input  logic               cpu_req,
    input  logic [ROW_W-1:0]   cpu_row,
    output logic               cpu_ready,
    output logic               hold_req,
    input  logic               hold_ack,
    output logic               cmd_valid,
    output logic [1:0]         cmd_kind,
    output logic [ROW_W-1:0]   cmd_row
);

    localparam int BUSY_W = (CMD_CYCLES > 1) ? $clog2(CMD_CYCLES) : 1;
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
    localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(CMD_CYCLES - 1);

    typedef struct packed {
        sched_st_e          st;
        logic               pend;
        logic               sweep;
        logic [ROW_W-1:0]   row;
        logic [BUSY_W-1:0]  busy;
        logic               hold;
        logic               cv;
        cmd_kind_e          kind;
        logic [ROW_W-1:0]   crow;
    } sched_t;

    sched_t s_q, s_d;

    logic             tick;
    logic             fifo_empty;
    logic [ROW_W-1:0] head_row;
    logic             push_lo, push_hi, pop;
    logic [ROW_W-1:0] lo_row, hi_row;
    logic             ready_c;

    dref_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_interval),
        .tick         (tick)
    );

    dref_nbr_fifo #(.ROW_W(ROW_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_lo  (push_lo),
        .lo_row   (lo_row),
        .push_hi  (push_hi),
        .hi_row   (hi_row),
        .pop      (pop),
        .empty    (fifo_empty),
        .head_row (head_row)
    );

    assign lo_row  = cpu_row - 1'b1;
    assign hi_row  = cpu_row + 1'b1;
    assign ready_c = (s_q.st == ST_IDLE) && !s_q.pend && fifo_empty;

    always_comb begin
        s_d     = s_q;
        s_d.cv  = 1'b0;
        s_d.kind = CMD_NOP;
        push_lo = 1'b0;
        push_hi = 1'b0;
        pop     = 1'b0;
        if (tick) s_d.pend = 1'b1;

        unique case (s_q.st)
            ST_IDLE: begin
                if (ready_c && cpu_req) begin
                    s_d.cv   = 1'b1;
                    s_d.kind = CMD_ACT;
                    s_d.crow = cpu_row;
                    push_lo  = (cpu_row != '0);
                    push_hi  = (cpu_row != LAST_ROW);
                end else if (s_q.pend || !fifo_empty) begin
                    s_d.hold = 1'b1;
                    s_d.st   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hold_ack) begin
                    s_d.st    = ST_RUN;
                    s_d.sweep = s_q.pend;
                    s_d.pend  = tick;
                    s_d.row   = '0;
                    s_d.busy  = '0;
                end
            end
            ST_RUN: begin
                if (s_q.busy != '0) begin
                    s_d.busy = s_q.busy - 1'b1;
                end else if (!fifo_empty) begin
                    pop      = 1'b1;
                    s_d.cv   = 1'b1;
                    s_d.kind = CMD_REF;
                    s_d.crow = head_row;
                    s_d.busy = BUSY_LOAD;
                end else if (s_q.sweep) begin
                    s_d.cv   = 1'b1;
                    s_d.kind = CMD_REF;
                    s_d.crow = s_q.row;
                    s_d.busy = BUSY_LOAD;
                    if (s_q.row == LAST_ROW) s_d.sweep = 1'b0;
                    else                     s_d.row   = s_q.row + 1'b1;
                end else begin
                    s_d.hold = 1'b0;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_ready = ready_c;
    assign hold_req  = s_q.hold;
    assign cmd_valid = s_q.cv;
    assign cmd_kind  = s_q.kind;
    assign cmd_row   = s_q.crow;

endmodule

// File: rtl/dref_sched_chk.sv
module dref_sched_chk #(
    parameter int ROWS       = 8192,
    parameter int CMD_CYCLES = 4,
    parameter int ROW_W      = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ready,
    input logic             hold_req,
    input logic             hold_ack,
    input logic             cmd_valid,
    input logic [1:0]       cmd_kind,
    input logic [ROW_W-1:0] cmd_row
);

    localparam int GAP_W = $clog2(CMD_CYCLES + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(CMD_CYCLES);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic [GAP_W-1:0] since_ref;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since_ref <= GAP_MIN;
        else if (cmd_valid && cmd_kind == 2'd2)
            since_ref <= GAP_W'(1);
        else if (since_ref < GAP_MIN)
            since_ref <= since_ref + 1'b1;
    end

    AST_REF_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2) |-> (hold_req && hold_ack)); // R2

    AST_READY_LOW_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> !cpu_ready); // R3

    AST_ACT_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd1) |-> !hold_req); // R3

    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_row <= LAST_ROW)); // R4

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_kind == 2'd1 || cmd_kind == 2'd2)); // R4

    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2) |-> (since_ref >= GAP_MIN)); // R7

    AST_STALL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd1 && cmd_row != '0) |-> !cpu_ready); // R10

endmodule

bind dref_sched dref_sched_chk #(
    .ROWS       (ROWS),
    .CMD_CYCLES (CMD_CYCLES),
    .ROW_W      (ROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .hold_req  (hold_req),
    .hold_ack  (hold_ack),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_row   (cmd_row)
);

// File: tb/dref_sched_test.sv
`timescale 1ns/1ps
module dref_sched_test;

    localparam int ROWS = 8;
    localparam int CC   = 2;
    localparam int TW   = 12;
    localparam int RW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] cfg_interval = '0;
    logic          cpu_req = 1'b0;
    logic [RW-1:0] cpu_row = '0;
    logic          cpu_ready;
    logic          hold_req;
    logic          hold_ack = 1'b0;
    logic          cmd_valid;
    logic [1:0]    cmd_kind;
    logic [RW-1:0] cmd_row;

    always #2.5 clk = ~clk;

    dref_sched #(.ROWS(ROWS), .TIMER_W(TW), .CMD_CYCLES(CC), .FIFO_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
        .cpu_req(cpu_req), .cpu_row(cpu_row), .cpu_ready(cpu_ready),
        .hold_req(hold_req), .hold_ack(hold_ack),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row)
    );

    typedef struct {
        int    kind;
        int    row;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   ack_delay = 0;
    int   ack_wait = 0;
    int   rises = 0;
    int   rise_cyc[$];
    int   last_ref = -1;
    bit   hold_cont = 1'b0;
    bit   prev_hold = 1'b0;
    bit   done = 1'b0;
    exp_t cur;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input int kind, input int row, input string tag);
        exp_t e;
        e.kind = kind; e.row = row; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // hold acknowledge model: answers after ack_delay cycles
    always @(posedge clk) begin
        #1;
        if (!rst_n || !hold_req) begin
            hold_ack = 1'b0;
            ack_wait = 0;
        end else if (!hold_ack) begin
            if (ack_wait >= ack_delay) hold_ack = 1'b1;
            else ack_wait++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected command kind", int'(cmd_kind), 0);
                end else begin
                    cur = exp_q.pop_front();
                    chk(int'(cmd_kind) == cur.kind, cur.tag, "command kind", int'(cmd_kind), cur.kind);
                    chk(int'(cmd_row) == cur.row, cur.tag, "command row", int'(cmd_row), cur.row);
                end
                if (cmd_kind == 2'd2) begin
                    chk(hold_ack && hold_req, "R2", "refresh without grant", int'(hold_ack), 1);
                    if (hold_cont && last_ref >= 0)
                        chk(cyc - last_ref == CC, "R7", "refresh spacing", cyc - last_ref, CC);
                    last_ref  = cyc;
                    hold_cont = 1'b1;
                end
            end
            if (hold_req && cpu_ready)
                chk(1'b0, "R3", "cpu_ready during hold", 1, 0);
            if (!prev_hold && hold_req) begin
                rises++;
                rise_cyc.push_back(cyc);
            end
            if (prev_hold && !hold_req)
                chk(cyc - last_ref == CC, "R8", "release delay after last refresh", cyc - last_ref, CC);
            if (!hold_req) hold_cont = 1'b0;
            prev_hold = hold_req;
        end
    end

    task automatic cpu_access(input int row, input string act_tag);
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_row = RW'(row);
        while (!cpu_ready) @(negedge clk);
        push_exp(1, row, act_tag);
        if (row > 0)
            push_exp(2, row - 1, (row == ROWS - 1) ? "R6" : "R5");
        if (row < ROWS - 1)
            push_exp(2, row + 1, (row == 0) ? "R6" : "R5");
        @(negedge clk);
        cpu_req = 1'b0;
        chk(!cpu_ready, "R10", "cpu_ready while neighbours queued", int'(cpu_ready), 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() != 0 || hold_req) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!hold_req, "R11", "hold_req after reset", int'(hold_req), 0);
        chk(!cmd_valid, "R11", "cmd_valid after reset", int'(cmd_valid), 0);
        chk(cpu_ready, "R11", "cpu_ready after reset", int'(cpu_ready), 1);

        // timer disabled: nothing happens
        repeat (60) @(negedge clk);
        chk(rises == 0, "R1", "sessions with interval 0", rises, 0);

        // interior, first and last rows
        cpu_access(3, "R5");
        cpu_access(0, "R6");
        cpu_access(7, "R6");
        wait_idle();
        chk(cpu_ready, "R8", "cpu_ready after release", int'(cpu_ready), 1);

        // slow grant, second request held during the neighbour session
        ack_delay = 6;
        cpu_access(2, "R5");
        cpu_access(6, "R3");
        wait_idle();
        ack_delay = 0;
        chk(cpu_ready, "R3", "cpu_ready after held request served", int'(cpu_ready), 1);

        // periodic sweeps at a fixed interval
        r0 = rises;
        rise_cyc.delete();
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < ROWS; r++) push_exp(2, r, "R4");
        cfg_interval = TW'(30);
        while (rises < r0 + 3) @(negedge clk);
        cfg_interval = '0;
        chk(rise_cyc[1] - rise_cyc[0] == 30, "R1", "session spacing", rise_cyc[1] - rise_cyc[0], 30);
        chk(rise_cyc[2] - rise_cyc[1] == 30, "R1", "session spacing", rise_cyc[2] - rise_cyc[1], 30);
        wait_idle();

        // expiries inside a sweep collapse into one further sweep
        r0 = rises;
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < ROWS; r++) push_exp(2, r, "R9");
        cfg_interval = TW'(4);
        while (rises < r0 + 1) @(negedge clk);
        while (hold_req) @(negedge clk);
        cfg_interval = '0;
        chk(!cpu_ready, "R9", "pending request blocks cpu after sweep", int'(cpu_ready), 0);
        wait_idle();
        repeat (80) @(negedge clk);
        chk(rises == r0 + 2, "R9", "sweep count", rises - r0, 2);
        chk(exp_q.size() == 0, "R9", "outstanding expected commands", exp_q.size(), 0);
        finish_run();
    end

endmodule